// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block sits beside the management register set of an Ethernet PHY. It turns changes in the live status of the PHY into a single active-low interrupt line. Each of nine status inputs is sampled every clock. The block watches them for the edges that set a sticky flag, and for the other edges that clear it. The inputs are link state, auto-negotiation completion, remote fault, parallel detection fault, page received, energy presence, transmit elastic buffer overflow and underflow, and idle error counter overflow.

Software reaches a mask register and a flag register through a small synchronous register port. Some flags also clear as a side effect of reads aimed at other status registers of the PHY: the basic status register, the auto-negotiation expansion register and the idle error counter register. The block observes those read strobes on the same port. A restart of auto-negotiation, given as a one-cycle pulse, also clears the flags that belong to negotiation.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0, the flag register reads 0 and irq_n is high.
- R2: irq_n is low exactly when some flag bit and its mask bit are both 1. A flag with a 0 mask bit has no effect on irq_n.
- R3: The mask register sits at address 30 and the flag register at address 29. Only bits 10..4, 2 and 1 exist. Bits 15..11 and bit 3 read 0 in both. Writes to address 29 change nothing, and any other address reads 0.
- R4: A status input is compared with its value at the previous clock. Bit 6 (auto-negotiation complete) and bit 7 (energy present) set on a rising edge of their inputs. They clear on a falling edge of that input or on a read of address 29.
- R5: Bit 5 (remote fault) sets on a rising edge of its input. It clears on its falling edge, on a read of address 1, or on a read of address 29.
- R6: Bit 4 (link lost) sets on a falling edge of the link input. It clears on a read of address 1 or address 29.
- R7: Bit 2 (parallel detection fault) and bit 1 (page received) set on the rising edge of their inputs. They clear on their falling edge, on a read of address 6, on a read of address 29, on an auto-negotiation restart pulse, or on a falling edge of link.
- R8: Bit 10 (transmit buffer overflow) and bit 9 (underflow) set on a rising edge of their condition inputs and clear only when that condition falls. Reads of address 29 leave them set.
- R9: Bit 8 (idle error overflow) sets on a rising edge of its input. It clears only on a read of address 10, and a falling edge of the input does not clear it.
- R10: When a set event and a clear event for the same flag occur in the same cycle, the flag ends up set.
- R11: A read of address 29 returns the flag values from before the clear that the same read causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | ADDR_W | Register index for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (drives the clear-on-read side effects) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| st_link | input | 1 | Link up status |
| st_an_done | input | 1 | Auto-negotiation complete status |
| st_rem_fault | input | 1 | Remote fault status |
| st_pd_fault | input | 1 | Parallel detection fault status |
| st_page_rx | input | 1 | Page received status |
| st_energy | input | 1 | Energy present status |
| st_txbuf_ovf | input | 1 | Transmit elastic buffer overflow condition |
| st_txbuf_unf | input | 1 | Transmit elastic buffer underflow condition |
| st_idle_ovf | input | 1 | Idle error counter overflow condition |
| an_restart | input | 1 | One-cycle pulse on auto-negotiation restart |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: a 5-bit address, 16-bit data and the standard register indices 1, 6, 10, 29 and 30. With these values every clear-on-read path is reachable through the address decode. The reserved bit positions also fall inside the data word, so the bench can observe them. The bench drives each status input through isolated rising and falling edges. It issues reads of each side-effect address, and it lines up a set edge with a clearing read in the same cycle. Both the R10 priority and the R11 pre-clear read value can therefore be seen at the port.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  // positions of the status inputs inside the sampled status vector
  localparam int SRC_N       = 9;
  localparam int S_LINK      = 0;
  localparam int S_AN        = 1;
  localparam int S_RFLT      = 2;
  localparam int S_PDF       = 3;
  localparam int S_PAGE      = 4;
  localparam int S_ENERGY    = 5;
  localparam int S_TXOVF     = 6;
  localparam int S_TXUNF     = 7;
  localparam int S_IDLE      = 8;

  // flag bit positions (software sees these)
  localparam int F_PAGE      = 1;
  localparam int F_PDF       = 2;
  localparam int F_LINKDN    = 4;
  localparam int F_RFLT      = 5;
  localparam int F_AN        = 6;
  localparam int F_ENERGY    = 7;
  localparam int F_IDLE      = 8;
  localparam int F_TXUNF     = 9;
  localparam int F_TXOVF     = 10;

  localparam logic [15:0] FLAG_IMPL = 16'h07F6;
endpackage

// File: rtl/phy_irq_edge.sv
module phy_irq_edge #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = sig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
endmodule

// File: rtl/phy_irq_flag.sv
module phy_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic en;
  logic d;

  always_comb begin
    en = set | clr;
    d  = set;          // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs #(
  parameter int          ADDR_W   = 5,
  parameter int          DATA_W   = 16,
  parameter int          MASK_IDX = 30,
  parameter int          FLAG_IDX = 29,
  parameter logic [DATA_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_IDX);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_IDX);

  logic              mask_en;
  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] mask_q;

  always_comb begin
    mask_en = reg_wr && (reg_addr == A_MASK);
    mask_d  = reg_wdata & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask = mask_q;

  always_comb begin
    unique case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_FLAG:  reg_rdata = flags & IMPL;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int MASK_IDX = 30,
  parameter int FLAG_IDX = 29,
  parameter int BSR_IDX  = 1,
  parameter int ANX_IDX  = 6,
  parameter int IDLE_IDX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              st_link,
  input  logic              st_an_done,
  input  logic              st_rem_fault,
  input  logic              st_pd_fault,
  input  logic              st_page_rx,
  input  logic              st_energy,
  input  logic              st_txbuf_ovf,
  input  logic              st_txbuf_unf,
  input  logic              st_idle_ovf,
  input  logic              an_restart,
  output logic              irq_n
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(FLAG_IMPL);

  logic [SRC_N-1:0]  status;
  logic [SRC_N-1:0]  rise;
  logic [SRC_N-1:0]  fall;
  logic [DATA_W-1:0] set_v;
  logic [DATA_W-1:0] clr_v;
  logic [DATA_W-1:0] flag_q;
  logic [DATA_W-1:0] mask_q;
  logic              rd_flag;
  logic              rd_bsr;
  logic              rd_anx;
  logic              rd_idle;
  logic              neg_reset;

  always_comb begin
    status           = '0;
    status[S_LINK]   = st_link;
    status[S_AN]     = st_an_done;
    status[S_RFLT]   = st_rem_fault;
    status[S_PDF]    = st_pd_fault;
    status[S_PAGE]   = st_page_rx;
    status[S_ENERGY] = st_energy;
    status[S_TXOVF]  = st_txbuf_ovf;
    status[S_TXUNF]  = st_txbuf_unf;
    status[S_IDLE]   = st_idle_ovf;
  end

  phy_irq_edge #(.W(SRC_N)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (status),
    .rise (rise),
    .fall (fall)
  );

  // read side effects
  always_comb begin
    rd_flag = reg_rd && (reg_addr == ADDR_W'(FLAG_IDX));
    rd_bsr  = reg_rd && (reg_addr == ADDR_W'(BSR_IDX));
    rd_anx  = reg_rd && (reg_addr == ADDR_W'(ANX_IDX));
    rd_idle = reg_rd && (reg_addr == ADDR_W'(IDLE_IDX));
    // anything that ends the current negotiation round
    neg_reset = rd_flag || rd_anx || an_restart || fall[S_LINK];
  end

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_TXOVF]  = rise[S_TXOVF];
    clr_v[F_TXOVF]  = fall[S_TXOVF];
    set_v[F_TXUNF]  = rise[S_TXUNF];
    clr_v[F_TXUNF]  = fall[S_TXUNF];
    set_v[F_IDLE]   = rise[S_IDLE];
    clr_v[F_IDLE]   = rd_idle;
    set_v[F_ENERGY] = rise[S_ENERGY];
    clr_v[F_ENERGY] = fall[S_ENERGY] || rd_flag;
    set_v[F_AN]     = rise[S_AN];
    clr_v[F_AN]     = fall[S_AN] || rd_flag;
    set_v[F_RFLT]   = rise[S_RFLT];
    clr_v[F_RFLT]   = fall[S_RFLT] || rd_flag || rd_bsr;
    set_v[F_LINKDN] = fall[S_LINK];
    clr_v[F_LINKDN] = rd_flag || rd_bsr;
    set_v[F_PDF]    = rise[S_PDF];
    clr_v[F_PDF]    = fall[S_PDF] || neg_reset;
    set_v[F_PAGE]   = rise[S_PAGE];
    clr_v[F_PAGE]   = fall[S_PAGE] || neg_reset;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_flag
    if (IMPL[b]) begin : g_cell
      phy_irq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_v[b]),
        .clr  (clr_v[b]),
        .q    (flag_q[b])
      );
    end else begin : g_rsvd
      assign flag_q[b] = 1'b0;
    end
  end

  phy_irq_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MASK_IDX(MASK_IDX),
    .FLAG_IDX(FLAG_IDX),
    .IMPL    (IMPL)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .flags    (flag_q),
    .mask     (mask_q),
    .reg_rdata(reg_rdata)
  );

  assign irq_n = ~|(flag_q & mask_q);
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int IDLE_IDX = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              st_link,
  input logic              st_an_done,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] flag_q,
  input logic              irq_n
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: nothing enabled means no interrupt
  a_r1_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> irq_n);

  // R2: an enabled link-lost event pulls the line low on the next cycle
  a_r2_enabled_event_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reg_wr && mask_q[4] && $fell(st_link)) |=> !irq_n);

  // R3: reserved positions never read back as 1
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:11] == 5'd0) && (reg_rdata[3] == 1'b0));

  // R4: rising completion latches its flag
  a_r4_an_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(st_an_done)) |=> flag_q[6]);

  // R6: falling link latches the link-lost flag
  a_r6_link_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(st_link)) |=> flag_q[4]);

  // R9: idle overflow flag only leaves on its own register read
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[8] && !(reg_rd && reg_addr == ADDR_W'(IDLE_IDX))) |=> flag_q[8]);
endmodule

bind phy_irq_ctrl phy_irq_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .IDLE_IDX(IDLE_IDX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .st_link   (st_link),
  .st_an_done(st_an_done),
  .mask_q    (mask_q),
  .flag_q    (flag_q),
  .irq_n     (irq_n)
);

// File: tb/sim_phy_irq_ctrl.sv
module sim_phy_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic st_link = 0, st_an_done = 0, st_rem_fault = 0, st_pd_fault = 0;
  logic st_page_rx = 0, st_energy = 0, st_txbuf_ovf = 0, st_txbuf_unf = 0;
  logic st_idle_ovf = 0, an_restart = 0;
  logic irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_link(st_link), .st_an_done(st_an_done), .st_rem_fault(st_rem_fault),
    .st_pd_fault(st_pd_fault), .st_page_rx(st_page_rx), .st_energy(st_energy),
    .st_txbuf_ovf(st_txbuf_ovf), .st_txbuf_unf(st_txbuf_unf),
    .st_idle_ovf(st_idle_ovf), .an_restart(an_restart), .irq_n(irq_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int   m_mask, m_flag;
  bit   p_link, p_an, p_rf, p_pd, p_pg, p_en, p_ov, p_un, p_id;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_flag = 0;
      {p_link, p_an, p_rf, p_pd, p_pg, p_en, p_ov, p_un, p_id} = '0;
    end else begin
      bit r29, r1, r6, r10, lfall, nego;
      int f;
      r29 = reg_rd && reg_addr == 29;
      r1  = reg_rd && reg_addr == 1;
      r6  = reg_rd && reg_addr == 6;
      r10 = reg_rd && reg_addr == 10;
      lfall = p_link && !st_link;
      nego = r29 || r6 || an_restart || lfall;
      f = m_flag;
      // clears first, then sets so that sets win (R10)
      if ((p_ov && !st_txbuf_ovf)) f[10] = 0;
      if ((p_un && !st_txbuf_unf)) f[9] = 0;
      if (r10) f[8] = 0;
      if ((p_en && !st_energy) || r29) f[7] = 0;
      if ((p_an && !st_an_done) || r29) f[6] = 0;
      if ((p_rf && !st_rem_fault) || r29 || r1) f[5] = 0;
      if (r29 || r1) f[4] = 0;
      if ((p_pd && !st_pd_fault) || nego) f[2] = 0;
      if ((p_pg && !st_page_rx) || nego) f[1] = 0;
      if (!p_ov && st_txbuf_ovf) f[10] = 1;
      if (!p_un && st_txbuf_unf) f[9] = 1;
      if (!p_id && st_idle_ovf) f[8] = 1;
      if (!p_en && st_energy) f[7] = 1;
      if (!p_an && st_an_done) f[6] = 1;
      if (!p_rf && st_rem_fault) f[5] = 1;
      if (lfall) f[4] = 1;
      if (!p_pd && st_pd_fault) f[2] = 1;
      if (!p_pg && st_page_rx) f[1] = 1;
      m_flag = f;
      if (reg_wr && reg_addr == 30) m_mask = reg_wdata & 16'h07F6;
      p_link = st_link; p_an = st_an_done; p_rf = st_rem_fault;
      p_pd = st_pd_fault; p_pg = st_page_rx; p_en = st_energy;
      p_ov = st_txbuf_ovf; p_un = st_txbuf_unf; p_id = st_idle_ovf;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_rd;
      exp_rd = (reg_addr == 30) ? m_mask : (reg_addr == 29) ? m_flag : 0;
      check("R2 irq_n vs model", int'(irq_n), ((m_flag & m_mask) != 0) ? 0 : 1);
      check("R3 rdata vs model", int'(reg_rdata), exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 5'(a); reg_wdata = 16'(d); reg_wr = 1;
    step(); reg_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 5'(a); reg_rd = 1;
    @(negedge clk); v = int'(reg_rdata);
    step(); reg_rd = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int v;
    step(3);
    rst_n = 1;
    step();
    // R1
    check("R1 irq_n after reset", int'(irq_n), 1);
    rd(30, v); check("R1 mask after reset", v, 0);
    rd(29, v); check("R1 flags after reset", v, 0);

    // R3
    wr(30, 16'hFFFF);
    rd(30, v); check("R3 mask reserved bits", v, 16'h07F6);
    wr(29, 16'hFFFF);
    rd(29, v); check("R3 flag reg not writable", v, 0);
    rd(5, v);  check("R3 unmapped address", v, 0);

    // R4 / R11
    st_an_done = 1; step(2);
    check("R4 an flag raises irq", int'(irq_n), 0);
    rd(29, v); check("R11 pre-clear read value", v, 16'h0040);
    rd(29, v); check("R4 read 29 clears an", v, 0);
    st_an_done = 0; step();
    st_an_done = 1; step(); st_an_done = 0; step(2);
    rd(29, v); check("R4 falling edge clears an", v, 0);
    st_energy = 1; step(2);
    rd(29, v); check("R4 energy rise sets", v, 16'h0080);
    st_energy = 0; step();

    // R5
    st_rem_fault = 1; step(2);
    check("R5 remote fault raises irq", int'(irq_n), 0);
    rd(1, v); check("R5 addr 1 reads zero", v, 0);
    rd(29, v); check("R5 read of 1 clears rf", v, 0);
    st_rem_fault = 0; step();

    // R6
    st_link = 1; step(2);
    check("R6 link up no flag", int'(irq_n), 1);
    st_link = 0; step(2);
    rd(29, v); check("R6 link fall sets", v, 16'h0010);
    st_link = 1; step(); st_link = 0; step(2);
    rd(1, v);
    rd(29, v); check("R6 read of 1 clears link lost", v, 0);

    // R7
    st_pd_fault = 1; st_page_rx = 1; step(2);
    rd(29, v); check("R7 pd and page set", v, 16'h0006);
    st_pd_fault = 0; st_page_rx = 0; step();
    st_pd_fault = 1; st_page_rx = 1; step(2);
    rd(6, v);
    rd(29, v); check("R7 read of 6 clears", v, 0);
    st_pd_fault = 0; st_page_rx = 0; step();
    st_pd_fault = 1; st_page_rx = 1; step(2);
    an_restart = 1; step(); an_restart = 0; step();
    check("R7 restart clears", int'(irq_n), 1);
    st_pd_fault = 0; st_page_rx = 0; step();
    st_pd_fault = 1; st_page_rx = 1; st_link = 1; step(2);
    st_link = 0; step(2);
    rd(29, v); check("R7 link fall clears, sets link lost", v, 16'h0010);
    st_pd_fault = 0; st_page_rx = 0; step();

    // R8
    st_txbuf_ovf = 1; step(2);
    rd(29, v); check("R8 overflow set", v, 16'h0400);
    rd(29, v); check("R8 read 29 keeps overflow", v, 16'h0400);
    st_txbuf_ovf = 0; step(2);
    rd(29, v); check("R8 overflow cleared by condition end", v, 0);
    st_txbuf_unf = 1; step(2);
    st_txbuf_unf = 0; step(2);
    check("R8 underflow cleared", int'(irq_n), 1);

    // R9
    st_idle_ovf = 1; step(2);
    st_idle_ovf = 0; step(2);
    rd(29, v); check("R9 idle flag survives fall", v, 16'h0100);
    rd(29, v); check("R9 idle flag survives read 29", v, 16'h0100);
    rd(10, v);
    rd(29, v); check("R9 read of 10 clears idle", v, 0);

    // R10
    reg_addr = 29; reg_rd = 1; st_an_done = 1;
    step(); reg_rd = 0;
    rd(29, v); check("R10 set wins over read clear", v, 16'h0040);
    st_an_done = 0; step(2);

    // R2 mask selectivity
    wr(30, 16'h0040);
    st_energy = 1; step(2);
    check("R2 masked flag leaves irq_n high", int'(irq_n), 1);
    wr(30, 16'h0080);
    check("R2 enabling flag drives irq_n low", int'(irq_n), 0);
    st_energy = 0; step(2);
    check("R2 irq_n released", int'(irq_n), 1);

    step(4);
    finish_run();
  end
endmodule